// File: doc/BRIEF.md
# Antenna Carrier Generator with Tunable Sampling Phase

This block turns an 8 MHz reference clock into the 125 kHz square wave that drives a series-tuned reader antenna. It produces the wave as two complementary driver enables. Driving `drive_on` low switches both drivers off, which is how a host writes amplitude modulation into the field. The block also issues a short strobe, once per carrier period, that tells an external sample-and-hold circuit when to capture the antenna voltage. The strobe's position is set by a 4-bit phase code measured from the falling edge of the first driver output.

The phase code is re-tuned only inside a timed preset window, during which the external integrating capacitor is also preloaded. The window opens a fixed delay after reset, after a wake-up pulse, or after the drivers are switched back on. While the window is open, the code moves one step per carrier period in the direction given by an external comparator. At all other times the comparator input has no effect.

Top module: `carrier_phase_gen`

## Requirements
- R1: While reset is held, `phase_code` is 8 (+11.25°) and `preset_win` is low. With `drive_on` high, the drivers run once reset is released.
- R2: With `drive_on` high, `drv_a` is a square wave with a period of 64 clocks and a high time of 32 clocks, and `drv_b` is always its complement.
- R3: While `drive_on` is low, both `drv_a` and `drv_b` are low.
- R4: Code c stands for an offset of (c-7)×11.25°, so code 0 is -78.75° and code 15 is +90°. One step is one 4 MHz tick, which is 2 clocks. The strobe rises 2×((c-7) mod 32) clocks after the sample in which `drv_a` has fallen.
- R5: `sample_stb` is high for exactly 4 consecutive clocks (500 ns) once per carrier period.
- R6: After reset is released, `preset_win` goes high after WAKE_DELAY rising edges. It then stays high for WIN_LEN clocks.
- R7: A one-clock `wake` pulse opens the window WAKE_DELAY clocks after the edge that captures it, so it is visible at the (WAKE_DELAY+1)-th edge counting the capture edge. The window stays open for WIN_LEN clocks.
- R8: A rising edge of `drive_on` opens the window ON_DELAY clocks after the edge that captures it. The window stays open for WIN_LEN clocks.
- R9: While the window is open, `phase_code` changes by one at each carrier-period wrap: +1 if `adj_up` is 1, -1 if it is 0. It saturates at 0 and 15.
- R10: While the window is closed, `adj_up` has no effect on `phase_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drive_on | input | 1 | Drivers enabled (1) or switched off for write modulation (0) |
| wake | input | 1 | One-clock wake-up indication |
| adj_up | input | 1 | Comparator verdict: 1 moves the sampling phase later, 0 earlier |
| drv_a | output | 1 | First antenna driver enable |
| drv_b | output | 1 | Second antenna driver enable, complement of `drv_a` |
| sample_stb | output | 1 | Sample-and-hold strobe |
| preset_win | output | 1 | Capacitor preload and phase re-tune window |
| phase_code | output | 4 | Current sampling-phase code |

## Verification
The bench keeps the default divider (prescale 2, 32 ticks, so a 64-clock carrier) and the 4-bit code. It shortens the window timing to ON_DELAY=100, WAKE_DELAY=150 and WIN_LEN=640. With 640 clocks, every window holds exactly ten carrier wraps, so the code after each window can be predicted exactly. This makes both saturation limits, and codes on both sides of 0°, reachable within a few thousand clocks. It also lets the reset, wake-up and driver-on delays be counted edge by edge.

// File: rtl/carrier_phase_gen.sv
module carrier_phase_gen #(
  parameter int PRESCALE   = 2,
  parameter int TICKS      = 32,
  parameter int CODE_W     = 4,
  parameter int ZERO_CODE  = 7,
  parameter int RESET_CODE = 8,
  parameter int STB_TICKS  = 2,
  parameter int ON_DELAY   = 2048,
  parameter int WAKE_DELAY = 4144,
  parameter int WIN_LEN    = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drive_on,
  input  logic              wake,
  input  logic              adj_up,
  output logic              drv_a,
  output logic              drv_b,
  output logic              sample_stb,
  output logic              preset_win,
  output logic [CODE_W-1:0] phase_code
);

  localparam int PW   = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int TW   = $clog2(TICKS);
  localparam int BASE = TICKS / 2 - ZERO_CODE + TICKS;
  localparam int DMAX = (ON_DELAY > WAKE_DELAY) ?
                        ((ON_DELAY > WIN_LEN) ? ON_DELAY : WIN_LEN) :
                        ((WAKE_DELAY > WIN_LEN) ? WAKE_DELAY : WIN_LEN);
  localparam int DW   = $clog2(DMAX + 1);
  localparam logic [CODE_W-1:0] CODE_TOP = '1;

  typedef enum logic [1:0] {T_IDLE, T_WAIT, T_WIN} tmr_state_t;

  logic [PW-1:0]     pre;
  logic [TW-1:0]     cnt;
  logic              tick, wrap;
  logic              drive_q, on_ev;
  tmr_state_t        state;
  logic [DW-1:0]     tmr;
  logic [TW-1:0]     stb_pos, stb_dist;

  assign tick  = (int'(pre) == PRESCALE - 1);
  assign wrap  = tick && (int'(cnt) == TICKS - 1);
  assign on_ev = drive_on && !drive_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre <= '0;
      cnt <= '0;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick) cnt <= cnt + 1'b1;
    end
  end

  assign drv_a = drive_on & ~cnt[TW-1];
  assign drv_b = drive_on &  cnt[TW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drive_q <= 1'b1;
      state   <= T_WAIT;
      tmr     <= DW'(WAKE_DELAY - 1);
    end else begin
      drive_q <= drive_on;
      if (wake) begin
        state <= T_WAIT;
        tmr   <= DW'(WAKE_DELAY - 1);
      end else if (on_ev) begin
        state <= T_WAIT;
        tmr   <= DW'(ON_DELAY - 1);
      end else if (state != T_IDLE) begin
        if (tmr == '0) begin
          state <= (state == T_WAIT) ? T_WIN : T_IDLE;
          tmr   <= DW'(WIN_LEN - 1);
        end else begin
          tmr <= tmr - 1'b1;
        end
      end
    end
  end

  assign preset_win = (state == T_WIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_code <= CODE_W'(RESET_CODE);
    end else if (preset_win && wrap) begin
      if (adj_up && phase_code != CODE_TOP)
        phase_code <= phase_code + 1'b1;
      else if (!adj_up && phase_code != '0)
        phase_code <= phase_code - 1'b1;
    end
  end

  assign stb_pos    = TW'((BASE + int'(phase_code)) % TICKS);
  assign stb_dist   = cnt - stb_pos;
  assign sample_stb = (int'(stb_dist) < STB_TICKS);

endmodule

// File: rtl/carrier_phase_chk.sv
module carrier_phase_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              drive_on,
  input logic              drv_a,
  input logic              drv_b,
  input logic              sample_stb,
  input logic              preset_win,
  input logic [CODE_W-1:0] phase_code
);

  // R2
  drv_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_a && drv_b));

  // R3
  drv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_on |-> (!drv_a && !drv_b));

  // R5
  stb_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sample_stb) |=> sample_stb);

  // R10
  code_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase_code) |-> $past(preset_win));

  // R9
  code_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase_code) |->
      (({1'b0, phase_code} == {1'b0, $past(phase_code)} + 1'b1) ||
       ({1'b0, phase_code} + 1'b1 == {1'b0, $past(phase_code)})));

endmodule

bind carrier_phase_gen carrier_phase_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .drive_on(drive_on), .drv_a(drv_a), .drv_b(drv_b),
  .sample_stb(sample_stb), .preset_win(preset_win), .phase_code(phase_code)
);

// File: tb/test_carrier_phase_gen.sv
module test_carrier_phase_gen;
  localparam int CLK_PERIOD = 10;
  localparam int ON_D = 100, WAKE_D = 150, WLEN = 640;

  logic clk = 0, rst_n = 0, drive_on = 1, wake = 0, adj_up = 0;
  logic drv_a, drv_b, sample_stb, preset_win;
  logic [3:0] phase_code;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  // each entry: {adj_up, expected code after one window}
  localparam logic [4:0] VEC [5] = '{
    {1'b1, 4'd10}, {1'b1, 4'd15}, {1'b0, 4'd5}, {1'b0, 4'd0}, {1'b1, 4'd10}
  };

  carrier_phase_gen #(.ON_DELAY(ON_D), .WAKE_DELAY(WAKE_D), .WIN_LEN(WLEN))
    i_carrier_phase_gen (.clk(clk), .rst_n(rst_n), .drive_on(drive_on),
      .wake(wake), .adj_up(adj_up), .drv_a(drv_a), .drv_b(drv_b),
      .sample_stb(sample_stb), .preset_win(preset_win), .phase_code(phase_code));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_offset(input int c);
    return 2 * (((c - 7) % 32 + 32) % 32);
  endfunction

  task automatic open_count(output int n);
    n = 0;
    do begin @(negedge clk); n++; wake = 0; end while (!preset_win && n < 5000);
  endtask

  task automatic win_len(output int n);
    n = 1;
    while (preset_win && n < 5000) begin @(negedge clk); if (preset_win) n++; end
  endtask

  task automatic measure_strobe(output int off, output int wid, output int per, output int hi);
    logic pa, ps;
    int k;
    pa = drv_a;
    do begin @(negedge clk); if (pa && !drv_a) break; pa = drv_a; end while (1);
    ps = 1'b0; off = -1; wid = 0; per = 0; hi = 0; k = 0;
    for (int i = 0; i < 64; i++) begin
      if (off < 0 && sample_stb && !(i == 0 ? 1'b0 : ps)) off = i;
      ps = sample_stb;
      @(negedge clk);
    end
    pa = 1'b0;
    do begin
      per++; if (drv_a) hi++;
      if (drv_b === drv_a) chk(0, "R2 complement", drv_b, !drv_a);
      pa = drv_a; @(negedge clk); k++;
    end while (!(pa && !drv_a) && k < 200);
    per = per + 0;
    // strobe width over a fresh period
    ps = sample_stb;
    for (int i = 0; i < 64; i++) begin
      if (sample_stb) wid++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n, off, wid, per, hi;
    repeat (4) @(negedge clk);
    chk(phase_code == 4'd8, "R1 reset code", phase_code, 8);
    chk(!preset_win, "R1 window low in reset", preset_win, 0);
    rst_n = 1;
    n = 0;
    do begin @(negedge clk); n++; end while (!preset_win && n < 5000);
    chk(n == WAKE_D, "R6 reset window delay", n, WAKE_D);
    win_len(n);
    chk(n == WLEN, "R6 reset window length", n, WLEN);
    chk(phase_code == 4'd0, "R9 saturate low after reset window", phase_code, 0);

    measure_strobe(off, wid, per, hi);
    chk(per == 64, "R2 carrier period", per, 64);
    chk(hi == 32, "R2 carrier high time", hi, 32);
    chk(off == exp_offset(0), "R4 strobe offset code 0", off, exp_offset(0));
    chk(wid == 4, "R5 strobe width", wid, 4);

    foreach (VEC[i]) begin
      adj_up = VEC[i][4];
      drive_on = 0;
      repeat (3) @(negedge clk);
      chk(!drv_a && !drv_b, "R3 drivers off", {drv_a, drv_b}, 0);
      drive_on = 1;
      open_count(n);
      chk(n == ON_D + 1, "R8 driver-on window delay", n, ON_D + 1);
      win_len(n);
      chk(n == WLEN, "R8 window length", n, WLEN);
      chk(phase_code == VEC[i][3:0], "R9 code after window", phase_code, VEC[i][3:0]);
      measure_strobe(off, wid, per, hi);
      chk(off == exp_offset(VEC[i][3:0]), "R4 strobe offset", off, exp_offset(VEC[i][3:0]));
      chk(wid == 4, "R5 strobe width", wid, 4);
    end

    // R10: comparator input ignored outside the window
    for (int i = 0; i < 300; i++) begin
      adj_up = i[2];
      @(negedge clk);
    end
    chk(phase_code == 4'd10, "R10 code held outside window", phase_code, 10);
    chk(!preset_win, "R10 window closed", preset_win, 0);

    // R7: wake-up pulse
    adj_up = 1;
    @(negedge clk);
    wake = 1;
    open_count(n);
    chk(n == WAKE_D + 1, "R7 wake window delay", n, WAKE_D + 1);
    win_len(n);
    chk(n == WLEN, "R7 wake window length", n, WLEN);
    chk(phase_code == 4'd15, "R9 saturate high after wake window", phase_code, 15);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule